// File: doc/BRIEF.md
# Multi-Mode Serial Port With Byte Register Access

This block is a full-duplex serial port that a processor drives through two byte-wide registers: a control/status register and a data register. A write to the data register loads the transmitter and starts a frame. A read of the data register returns the word held from the most recent completed reception. Transmit and receive run at the same time and do not share state. A two-bit mode field picks a clocked shift mode with no framing, an 8-bit framed mode, or a 9-bit framed mode; codes 10 and 11 both give the 9-bit frame. A one-bit data pulse (`tx_tick`) paces each transmitted bit. A pulse at sixteen times the bit rate (`rx_tick`) paces the receiver. Both pulses come from an outside rate generator.

The control register (bit 7 down to bit 0) holds SM0, SM1, SM2, REN, TB8, RB8, TI and RI. The mode field is {SM0,SM1}. Hardware sets TI when a frame has gone out and RI when a received word has been stored. Only a software write to the control register clears them. The interrupt request is the OR of the two flags, gated by an enable input.

The transmitter state machine uses TX_IDLE, TX_START, TX_DATA, TX_NINTH and TX_STOP. Its transitions are:
- load: TX_IDLE to TX_START, or to TX_DATA in shift mode.
- Each `tx_tick`: TX_START to TX_DATA.
- Last data bit: TX_DATA to TX_NINTH (9-bit), TX_STOP (8-bit) or TX_IDLE (shift).
- TX_NINTH to TX_STOP.
- TX_STOP to TX_IDLE.

The receiver state machine uses RX_IDLE, RX_START, RX_BITS and RX_STOP. Its transitions are:
- Start detect: RX_IDLE to RX_START, or to RX_BITS in shift mode.
- Valid start: RX_START to RX_BITS.
- False start: RX_START to RX_IDLE.
- Last bit: RX_BITS to RX_STOP, or to RX_IDLE in shift mode.
- End of stop bit: RX_STOP to RX_IDLE.

Top module: `sport_uart`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, `txd` is 1 and `irq` is 0.
- R2: Register address 1 is the data register and address 0 is the control register. In framed modes a data write sends a 0 start bit, the 8 data bits LSB first, and a 1 stop bit. Each bit lasts until the next `tx_tick`. In mode 00 the 8 data bits go out LSB first with no start or stop bit.
- R3: TI (control bit 1) is set on the `tx_tick` that ends the last bit of a frame. RI (control bit 0) is set when a received word is copied to the data register.
- R4: TI and RI stay set until software writes the control register with that bit at 0.
- R5: `irq` equals `irq_en` AND (TI OR RI).
- R6: In modes 10 and 11, TB8 (control bit 3) is sent as a ninth bit after the data, and the received ninth bit is stored in RB8 (control bit 2). In mode 01, RB8 takes the received stop bit.
- R7: With REN (control bit 4) at 0, no reception starts: RI stays 0 and the data register keeps its value.
- R8: Each received bit spans 16 `rx_tick`s. Its value is the majority of the samples at ticks 7, 8 and 9 of that span, so a line glitch on one sample does not change the word.
- R9: A start bit whose majority sample is 1 is dropped as a false start. The receiver returns to idle without setting RI and accepts the next frame.
- R10: In modes 10 and 11 with SM2 (control bit 5) at 1, a frame whose ninth bit is 0 is discarded: RI is not set and the data register is unchanged.
- R11: The data register keeps the previous word while the next frame is being received, and is overwritten only when that frame completes.
- R12: A data-register write while a transmission is in progress is ignored, and the frame in flight is unchanged.
- R13: In mode 00 with REN=1 and RI=0, reception starts at once, with no start bit. It takes 8 bits LSB first, one per 16 `rx_tick`s, then sets RI and stays idle while RI is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = data register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| tx_tick | input | 1 | One pulse per transmit bit period |
| rx_tick | input | 1 | Receive oversampling pulse, 16 per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions check on every cycle that:
- TI and RI are never cleared without a control-register write;
- a transmit or receive completion is followed by its flag;
- the transmitter only leaves idle on a load, and a load while busy leaves its shift register untouched;
- the receiver never leaves idle while REN is 0.

Only the bench's scenarios can show the rest:
- the exact bit order on `txd`;
- majority voting against a glitch;
- rejection of a false start;
- the SM2 address filter;
- the overlap between the holding register and a reception in progress;
- shift-mode reception.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_ASYNC8 = 2'b01,
        MODE_ASYNC9 = 2'b10,
        MODE_ASYNCX = 2'b11
    } sport_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_BITS, RX_STOP
    } rx_state_e;

    localparam int CTRL_RI  = 0;
    localparam int CTRL_TI  = 1;
    localparam int CTRL_RB8 = 2;
    localparam int CTRL_TB8 = 3;
    localparam int CTRL_REN = 4;
    localparam int CTRL_SM2 = 5;
    localparam int CTRL_SM1 = 6;
    localparam int CTRL_SM0 = 7;
endpackage

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        mode,
    input  logic              tb8,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  bit_q;
    logic              shift_q, nine_q, ninth_q;
    logic              last_data;

    assign last_data = (bit_q == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = (mode == MODE_SHIFT) ? TX_DATA : TX_START;
            TX_START: if (tick) state_d = TX_DATA;
            TX_DATA:  if (tick && last_data)
                          state_d = shift_q ? TX_IDLE : (nine_q ? TX_NINTH : TX_STOP);
            TX_NINTH: if (tick) state_d = TX_STOP;
            TX_STOP:  if (tick) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_q   <= '0;
            shift_q <= 1'b0;
            nine_q  <= 1'b0;
            ninth_q <= 1'b0;
        end else if (state_q == TX_IDLE && load) begin
            sh_q    <= data;
            bit_q   <= '0;
            shift_q <= (mode == MODE_SHIFT);
            nine_q  <= mode[1];
            ninth_q <= tb8;
        end else if (state_q == TX_DATA && tick) begin
            sh_q  <= sh_q >> 1;
            bit_q <= bit_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        txd = 1'b1;
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_NINTH: txd = ninth_q;
            default:  txd = 1'b1;
        endcase
        busy = (state_q != TX_IDLE);
        done = tick && ((state_q == TX_STOP) ||
                        (state_q == TX_DATA && shift_q && last_data));
    end

    p_busy_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load));

    p_load_ignored_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load && state_q != TX_DATA) |=> $stable(sh_q));
endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        mode,
    input  logic              ren,
    input  logic              ri,
    input  logic              sm2,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              rb_val
);
    localparam int OVS_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W + 2);
    localparam logic [OVS_W-1:0] SMP_A  = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] SMP_B  = OVS_W'(OVS / 2);
    localparam logic [OVS_W-1:0] SMP_C  = OVS_W'(OVS / 2 + 1);
    localparam logic [OVS_W-1:0] LAST_T = OVS_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST8  = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] LAST9  = BIT_W'(DATA_W);

    rx_state_e         state_q, state_d;
    logic              s1_q, rx_s;
    logic [OVS_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  nbit_q;
    logic [DATA_W:0]   sh_q;
    logic [2:0]        smp_q;
    logic              shift_q, nine_q, done_q, rb_q;
    logic              maj, bit_end, start_ok, last_bit, fin, accept;

    assign maj      = (smp_q[0] & smp_q[1]) | (smp_q[0] & smp_q[2]) | (smp_q[1] & smp_q[2]);
    assign bit_end  = tick && (cnt_q == LAST_T);
    assign start_ok = tick && ren && !done_q &&
                      ((mode == MODE_SHIFT) ? !ri : !rx_s);
    assign last_bit = (nbit_q == (nine_q ? LAST9 : LAST8));
    assign fin      = bit_end && ((state_q == RX_STOP) ||
                                  (state_q == RX_BITS && shift_q && last_bit));
    assign accept   = !(nine_q && sm2 && !sh_q[DATA_W]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            s1_q <= rxd;
            rx_s <= s1_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (start_ok) state_d = (mode == MODE_SHIFT) ? RX_BITS : RX_START;
            RX_START: if (bit_end)  state_d = maj ? RX_IDLE : RX_BITS;
            RX_BITS:  if (bit_end && last_bit) state_d = shift_q ? RX_IDLE : RX_STOP;
            RX_STOP:  if (bit_end)  state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // sampling and shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            nbit_q  <= '0;
            sh_q    <= '1;
            smp_q   <= '1;
            shift_q <= 1'b0;
            nine_q  <= 1'b0;
        end else if (state_q == RX_IDLE) begin
            if (start_ok) begin
                cnt_q   <= OVS_W'(1);
                nbit_q  <= '0;
                sh_q    <= '1;
                shift_q <= (mode == MODE_SHIFT);
                nine_q  <= mode[1];
            end
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (cnt_q == SMP_A) smp_q[0] <= rx_s;
            if (cnt_q == SMP_B) smp_q[1] <= rx_s;
            if (cnt_q == SMP_C) smp_q[2] <= rx_s;
            if (state_q == RX_BITS && bit_end) begin
                sh_q   <= {maj, sh_q[DATA_W:1]};
                nbit_q <= nbit_q + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            rb_q   <= 1'b0;
        end else begin
            done_q <= fin && accept;
            if (fin) rb_q <= nine_q ? sh_q[DATA_W] : maj;
        end
    end

    assign done   = done_q;
    assign rb_val = rb_q;
    assign word   = nine_q ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];

    p_idle_without_ren_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && !ren) |=> (state_q == RX_IDLE));

    p_shift_no_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (state_q == RX_IDLE));
endmodule

// File: rtl/sport_uart.sv
module sport_uart
    import sport_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_en,
    output logic       irq,
    input  logic       tx_tick,
    input  logic       rx_tick,
    input  logic       rxd,
    output logic       txd
);
    localparam int DATA_W = 8;

    logic [7:0]        ctrl_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              ctrl_wr, data_wr;
    logic              tx_busy, tx_done, rx_done, rx_rb;
    logic [DATA_W-1:0] rx_word;
    logic [1:0]        mode;

    assign ctrl_wr = reg_we && !reg_addr;
    assign data_wr = reg_we &&  reg_addr;
    assign mode    = {ctrl_q[CTRL_SM0], ctrl_q[CTRL_SM1]};

    sport_tx #(.DATA_W(DATA_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tx_tick),
        .load  (data_wr),
        .data  (reg_wdata),
        .mode  (mode),
        .tb8   (ctrl_q[CTRL_TB8]),
        .txd   (txd),
        .busy  (tx_busy),
        .done  (tx_done)
    );

    sport_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (rx_tick),
        .rxd    (rxd),
        .mode   (mode),
        .ren    (ctrl_q[CTRL_REN]),
        .ri     (ctrl_q[CTRL_RI]),
        .sm2    (ctrl_q[CTRL_SM2]),
        .done   (rx_done),
        .word   (rx_word),
        .rb_val (rx_rb)
    );

    // register file: software writes first, hardware sets win
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= reg_wdata;
            if (tx_done) ctrl_q[CTRL_TI] <= 1'b1;
            if (rx_done) begin
                ctrl_q[CTRL_RI] <= 1'b1;
                if (mode != MODE_SHIFT) ctrl_q[CTRL_RB8] <= rx_rb;
                rbuf_q <= rx_word;
            end
        end
    end

    assign reg_rdata = reg_addr ? rbuf_q : ctrl_q;
    assign irq       = irq_en && (ctrl_q[CTRL_TI] || ctrl_q[CTRL_RI]);

    p_ti_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_TI] && !ctrl_wr) |=> ctrl_q[CTRL_TI]);

    p_ri_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_RI] && !ctrl_wr) |=> ctrl_q[CTRL_RI]);

    p_ti_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> ctrl_q[CTRL_TI]);

    p_ri_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (ctrl_q[CTRL_RI] && rbuf_q == $past(rx_word)));
endmodule

// File: tb/sim_sport_uart.sv
`timescale 1ns/1ps
module sim_sport_uart;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_en = 1'b0;
    logic       irq;
    logic       tx_tick = 1'b0;
    logic       rx_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       txd;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sport_uart u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq),
        .tx_tick(tx_tick), .rx_tick(rx_tick), .rxd(rxd), .txd(txd)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic tx_expect(string tag, logic [15:0] bits, int from, int upto);
        for (int i = from; i < upto; i++) begin
            check(tag, 16'(txd), 16'(bits[i]));
            tx_tick = 1'b1;
            @(negedge clk);
            tx_tick = 1'b0;
        end
    endtask

    task automatic rx_bit(logic b, bit glitch);
        rxd = b;
        if (glitch) begin
            repeat (8) @(negedge clk);
            rxd = ~b;
            @(negedge clk);
            rxd = b;
            repeat (7) @(negedge clk);
        end else begin
            repeat (16) @(negedge clk);
        end
    endtask

    task automatic send_frame(logic [7:0] d, bit nine, logic ninth, bit glitch);
        rx_bit(1'b0, glitch);
        for (int i = 0; i < 8; i++) rx_bit(d[i], glitch);
        if (nine) rx_bit(ninth, glitch);
        rx_bit(1'b1, glitch);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); check("R1 ctrl", 16'(v), 16'h00);
        rd(1'b1, v); check("R1 data", 16'(v), 16'h00);
        check("R1 txd", 16'(txd), 16'h1);
        check("R1 irq", 16'(irq), 16'h0);
    endtask

    task automatic t_tx_async8;
        logic [7:0] v;
        wr(1'b0, 8'h40);
        wr(1'b1, 8'hA5);
        tx_expect("R2 async8 bit", {6'b0, 1'b1, 8'hA5, 1'b0}, 0, 3);
        rd(1'b0, v); check("R3 TI early", 16'(v[1]), 16'h0);
        wr(1'b1, 8'h3C);
        tx_expect("R12 busy write ignored", {6'b0, 1'b1, 8'hA5, 1'b0}, 3, 10);
        rd(1'b0, v); check("R3 TI set", 16'(v[1]), 16'h1);
        irq_en = 1'b1; #0.5;
        check("R5 irq on TI", 16'(irq), 16'h1);
        irq_en = 1'b0; #0.5;
        check("R5 irq gated", 16'(irq), 16'h0);
        irq_en = 1'b1;
        repeat (20) @(negedge clk);
        rd(1'b0, v); check("R4 TI sticky", 16'(v[1]), 16'h1);
        wr(1'b0, 8'h40);
        rd(1'b0, v); check("R4 TI cleared", 16'(v[1]), 16'h0);
        check("R5 irq drops", 16'(irq), 16'h0);
        check("R2 idle high", 16'(txd), 16'h1);
    endtask

    task automatic t_tx_shift;
        logic [7:0] v;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h96);
        tx_expect("R2 shift bit", {8'h00, 8'h96}, 0, 8);
        rd(1'b0, v); check("R3 TI shift", 16'(v[1]), 16'h1);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_tx_nine;
        wr(1'b0, 8'h88);
        wr(1'b1, 8'h0F);
        tx_expect("R6 ninth tx", {5'b0, 1'b1, 1'b1, 8'h0F, 1'b0}, 0, 11);
        wr(1'b0, 8'h80);
        wr(1'b1, 8'hF0);
        tx_expect("R6 ninth tx zero", {5'b0, 1'b1, 1'b0, 8'hF0, 1'b0}, 0, 11);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_rx_async8;
        logic [7:0] v;
        wr(1'b0, 8'h50);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v);
        check("R3 RI set", 16'(v[0]), 16'h1);
        check("R6 RB8 stop", 16'(v[2]), 16'h1);
        check("R5 irq on RI", 16'(irq), 16'h1);
        rd(1'b1, v); check("R2 rx word", 16'(v), 16'h5A);
        repeat (30) @(negedge clk);
        rd(1'b0, v); check("R4 RI sticky", 16'(v[0]), 16'h1);
        wr(1'b0, 8'h50);
        rd(1'b0, v); check("R4 RI cleared", 16'(v[0]), 16'h0);
    endtask

    task automatic t_rx_glitch;
        logic [7:0] v;
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
        rd(1'b1, v); check("R8 glitch majority", 16'(v), 16'hC3);
        wr(1'b0, 8'h50);
    endtask

    task automatic t_rx_false;
        logic [7:0] v;
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        rd(1'b0, v); check("R9 no RI on false start", 16'(v[0]), 16'h0);
        rd(1'b1, v); check("R9 buffer kept", 16'(v), 16'hC3);
        send_frame(8'h11, 1'b0, 1'b0, 1'b0);
        rd(1'b1, v); check("R9 recovers", 16'(v), 16'h11);
        wr(1'b0, 8'h40);
    endtask

    task automatic t_rx_ren;
        logic [7:0] v;
        send_frame(8'hEE, 1'b0, 1'b0, 1'b0);
        rd(1'b0, v); check("R7 no RI with REN=0", 16'(v[0]), 16'h0);
        rd(1'b1, v); check("R7 buffer kept", 16'(v), 16'h11);
    endtask

    task automatic t_rx_nine;
        logic [7:0] v;
        wr(1'b0, 8'h90);
        send_frame(8'h81, 1'b1, 1'b1, 1'b0);
        rd(1'b0, v); check("R6 RB8 ninth", 16'(v[2]), 16'h1);
        rd(1'b1, v); check("R6 nine word", 16'(v), 16'h81);
        wr(1'b0, 8'hB0);
        send_frame(8'h22, 1'b1, 1'b0, 1'b0);
        rd(1'b0, v); check("R10 filtered RI", 16'(v[0]), 16'h0);
        rd(1'b1, v); check("R10 filtered buffer", 16'(v), 16'h81);
        send_frame(8'h33, 1'b1, 1'b1, 1'b0);
        rd(1'b0, v); check("R10 addressed RI", 16'(v[0]), 16'h1);
        rd(1'b1, v); check("R10 addressed word", 16'(v), 16'h33);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_rx_overlap;
        logic [7:0] v;
        wr(1'b0, 8'h50);
        send_frame(8'h44, 1'b0, 1'b0, 1'b0);
        rx_bit(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) rx_bit(1'b1, 1'b0);
        rd(1'b1, v); check("R11 holds previous", 16'(v), 16'h44);
        for (int i = 4; i < 8; i++) rx_bit(1'b0, 1'b0);
        rx_bit(1'b1, 1'b0);
        repeat (8) @(negedge clk);
        rd(1'b1, v); check("R11 overwritten", 16'(v), 16'h0F);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_rx_shift;
        logic [7:0] v;
        wr(1'b0, 8'h10);
        for (int i = 0; i < 8; i++) rx_bit(((8'hB7 >> i) & 8'h01) != 0, 1'b0);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
        rd(1'b0, v); check("R13 shift RI", 16'(v[0]), 16'h1);
        rd(1'b1, v); check("R13 shift word", 16'(v), 16'hB7);
        rxd = 1'b0;
        repeat (200) @(negedge clk);
        rd(1'b1, v); check("R13 no restart while RI", 16'(v), 16'hB7);
        rxd = 1'b1;
        wr(1'b0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_async8();
        t_tx_shift();
        t_tx_nine();
        t_rx_async8();
        t_rx_glitch();
        t_rx_false();
        t_rx_ren();
        t_rx_nine();
        t_rx_overlap();
        t_rx_shift();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule